// File: doc/BRIEF.md
# Dual-Channel Multiplying Converter Code Latch

This block is the digital front end of a two-channel multiplying converter, modelled synchronously. A single 8-bit data port feeds two code registers. A channel-select input steers each write to one of them, and two active-low strobes, chip-select and write, open that register. While both strobes are low, the selected register follows the port on every clock. At all other times both registers keep their value. The strobes, the select and the data arrive asynchronously, so all of them pass through one two-flop synchronizer as a single bundle. This keeps the data aligned with its strobe.

Each channel multiplies its own 16-bit signed reference sample by its stored code and drives a registered 24-bit signed result. A shared mode input chooses between two transfer laws. The unipolar law gives the negated product of reference and code, read with eight fraction bits. The bipolar law reads the code as offset binary centred on 128 and gives the product read with seven fraction bits. In both cases the true value is the output shifted right arithmetically by 8 or by 7.

Top module: `dual_dac_latch`

## Requirements
- R1: While rst_n is low at a rising edge, both code registers become 0 and both outputs become 0.
- R2: With chan_sel low and cs_n and wr_n both low, the channel A register takes the synchronized data_in on every cycle. Bit 7 of data_in is the most significant bit.
- R3: With chan_sel high and cs_n and wr_n both low, the channel B register takes the synchronized data_in on every cycle.
- R4: When cs_n or wr_n is high, neither register changes, even if data_in changes.
- R5: The channel that chan_sel does not select never changes, whatever the strobes do.
- R6: With bipolar low, each output equals -(ref × code) as a 24-bit signed value. Code 0 gives 0, and code 255 gives -255·ref.
- R7: With bipolar high, each output equals ref × (code − 128) as a 24-bit signed value. Code 0x80 gives 0, 0xFF gives 127·ref and 0x00 gives −128·ref.
- R8: A write that is applied before rising edge k updates the register at edge k+2 and the output at edge k+3. A change of ref or bipolar reaches the output at the next edge.
- R9: While a write is held open over several cycles, the register tracks each new data value. After the strobe rises, the register keeps the last value that was synchronized before the rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 8 | Shared code port, bit 7 is the MSB |
| chan_sel | input | 1 | Channel select, 0 = A, 1 = B |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| bipolar | input | 1 | Transfer law, 0 = unipolar, 1 = offset-binary bipolar |
| ref_a | input | 16 | Channel A signed reference sample |
| ref_b | input | 16 | Channel B signed reference sample |
| out_a | output | 24 | Channel A signed product |
| out_b | output | 24 | Channel B signed product |

## Verification
Results appear at two different delays. A data write shows at the outputs four rising edges after the port is driven: two synchronizer stages, the code register and then the output register. A change of reference or mode shows after a single edge. The bench drives inputs on falling edges and samples on falling edges. In the latency test it samples right after the third edge, where the old value must still be present, and right after the fourth edge, where the new value must be present. Every other write check waits six edges, so the result has settled before the sample is taken.

// File: rtl/dac_latch_pkg.sv
// Package: shared widths, enumerations and the offset-binary helper for the
// dual-channel code latch. Assumes an 8-bit code and a two-channel select.
package dac_latch_pkg;
    localparam int CODE_W = 8;
    localparam int REF_W  = 16;
    localparam int OUT_W  = CODE_W + REF_W;

    typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} chan_e;
    typedef enum logic {LAW_UNI = 1'b0, LAW_BIP = 1'b1} law_e;

    // Returns code - 2^(W-1) as a signed value one bit wider than the code.
    function automatic logic signed [CODE_W:0] offset_code(input logic [CODE_W-1:0] c);
        return {~c[CODE_W-1], ~c[CODE_W-1], c[CODE_W-2:0]};
    endfunction
endpackage

// File: rtl/dac_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes the bundle is quasi-static around its strobe so that all bits
// are captured together; resets to RST_VAL.
module dac_sync #(
    parameter int          W       = 11,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // Shift the bundle one stage further toward the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else if (i == 0) stg[i] <= d;
                else stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_code_reg.sv
// Module: one channel's code register. Transparency is modelled as a load
// on every cycle in which load is high; it holds otherwise.
module dac_code_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the port while open, keep the last value when closed.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/dac_xfer.sv
// Module: per-channel transfer law. Unipolar: -(ref*code), 8 fraction bits.
// Bipolar: ref*(code-128), 7 fraction bits. Result is registered.
// Assumes OUT_W >= REF_W + CODE_W so no case overflows.
module dac_xfer
    import dac_latch_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int RW = REF_W,
    parameter int OW = OUT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bipolar,
    input  logic [CW-1:0]        code,
    input  logic signed [RW-1:0] ref_in,
    output logic signed [OW-1:0] result
);
    localparam int PW = OW + 1;

    logic signed [CW:0]   mult;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] prod_neg;
    logic signed [OW-1:0] nxt;

    // Pick the multiplier: plain code or offset-binary code.
    always_comb begin
        if (bipolar) mult = offset_code(code);
        else         mult = $signed({1'b0, code});
    end

    // Form the product and apply the sign of the selected law.
    always_comb begin
        prod     = PW'(ref_in) * PW'(mult);
        prod_neg = -prod;
        nxt      = bipolar ? prod[OW-1:0] : prod_neg[OW-1:0];
    end

    // Register the result for a clean output.
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else        result <= nxt;
    end
endmodule

// File: rtl/dual_dac_latch.sv
// Module: top of the dual-channel code latch. Synchronizes the shared data
// port, select and strobes, steers writes to one of NUM_CH code registers
// and computes each channel's product against its own reference.
module dual_dac_latch
    import dac_latch_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CODE_W-1:0]       data_in,
    input  logic                    chan_sel,
    input  logic                    cs_n,
    input  logic                    wr_n,
    input  logic                    bipolar,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    output logic signed [OUT_W-1:0] out_a,
    output logic signed [OUT_W-1:0] out_b
);
    localparam int BUNDLE_W = CODE_W + 3;
    localparam logic [BUNDLE_W-1:0] IDLE = {{CODE_W{1'b0}}, 1'b0, 1'b1, 1'b1};

    logic [BUNDLE_W-1:0] raw_bus;
    logic [BUNDLE_W-1:0] syn_bus;
    logic [CODE_W-1:0]   s_data;
    logic                s_sel;
    logic                s_cs_n;
    logic                s_wr_n;
    logic                s_go;

    logic [NUM_CH-1:0][CODE_W-1:0]       code_q;
    logic [NUM_CH-1:0][REF_W-1:0]        ref_v;
    logic [NUM_CH-1:0][OUT_W-1:0]        res_v;

    assign raw_bus = {data_in, chan_sel, cs_n, wr_n};

    dac_sync #(
        .W       (BUNDLE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (syn_bus)
    );

    // Split the synchronized bundle and decode the write condition.
    always_comb begin
        {s_data, s_sel, s_cs_n, s_wr_n} = syn_bus;
        s_go = !s_cs_n && !s_wr_n;
    end

    assign ref_v[CH_A] = ref_a;
    assign ref_v[CH_B] = ref_b;

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
            logic ld;
            assign ld = s_go && (s_sel == ch[0]);

            dac_code_reg #(.W(CODE_W)) u_code (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (ld),
                .d     (s_data),
                .q     (code_q[ch])
            );

            dac_xfer u_xfer (
                .clk     (clk),
                .rst_n   (rst_n),
                .bipolar (bipolar),
                .code    (code_q[ch]),
                .ref_in  (ref_v[ch]),
                .result  (res_v[ch])
            );
        end
    endgenerate

    assign out_a = res_v[CH_A];
    assign out_b = res_v[CH_B];
endmodule

// File: rtl/dual_dac_latch_chk.sv
// Checker: temporal properties of the dual-channel code latch, bound to the
// top. Observes ports plus the synchronizer and code-register outputs.
module dual_dac_latch_chk (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         data_in,
    input logic               bipolar,
    input logic signed [15:0] ref_a,
    input logic signed [15:0] ref_b,
    input logic signed [23:0] out_a,
    input logic signed [23:0] out_b,
    input logic [7:0]         s_data,
    input logic               s_sel,
    input logic               s_go,
    input logic [7:0]         code_a,
    input logic [7:0]         code_b
);
    logic [1:0] since_rst;
    logic       was_rst;

    // Count cycles since reset, saturating, and remember a reset cycle.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
    end

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (out_a == 24'sd0 && out_b == 24'sd0));

    p_write_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_go && !s_sel) |=> code_a == $past(s_data));

    p_write_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_go && s_sel) |=> code_b == $past(s_data));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_go && since_rst == 3) |=> ($stable(code_a) && $stable(code_b)));

    p_unsel_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_sel && since_rst == 3) |=> $stable(code_a));

    p_unsel_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_sel && since_rst == 3) |=> $stable(code_b));

    p_unipolar_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 0 && !$past(bipolar)) |->
        (out_a == 24'(-(32'($past(ref_a)) * 32'($past({1'b0, code_a}))))));

    p_bipolar_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 0 && $past(bipolar)) |->
        (out_b == 24'(32'($past(ref_b)) * (32'($past({1'b0, code_b})) - 32'sd128))));

    p_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3) |-> s_data == $past(data_in, 2));
endmodule

bind dual_dac_latch dual_dac_latch_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_in (data_in),
    .bipolar (bipolar),
    .ref_a   (ref_a),
    .ref_b   (ref_b),
    .out_a   (out_a),
    .out_b   (out_b),
    .s_data  (s_data),
    .s_sel   (s_sel),
    .s_go    (s_go),
    .code_a  (code_q[0]),
    .code_b  (code_q[1])
);

// File: tb/dual_dac_latch_tb.sv
module dual_dac_latch_tb;
    logic clk = 1'b0;
    logic rst_n;
    logic [7:0] data_in;
    logic chan_sel, cs_n, wr_n, bipolar;
    logic signed [15:0] ref_a, ref_b;
    logic signed [23:0] out_a, out_b;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    logic [7:0] m_a, m_b;   // bench model of the two codes

    always #4 clk = ~clk;   // 125 MHz

    dual_dac_latch u_dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .chan_sel(chan_sel),
        .cs_n(cs_n), .wr_n(wr_n), .bipolar(bipolar),
        .ref_a(ref_a), .ref_b(ref_b), .out_a(out_a), .out_b(out_b)
    );

    function automatic logic signed [23:0] expect_out(input logic signed [15:0] r,
                                                      input logic [7:0] c, input logic bip);
        int p;
        if (bip) p = int'(r) * (int'(c) - 128);
        else     p = -(int'(r) * int'(c));
        return p[23:0];
    endfunction

    task automatic check(input string tag, input logic signed [23:0] act,
                         input logic signed [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_both(input string tag);
        check({tag, " chA"}, out_a, expect_out(ref_a, m_a, bipolar));
        check({tag, " chB"}, out_b, expect_out(ref_b, m_b, bipolar));
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle write pulse, then settle.
    task automatic write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        chan_sel = sel; data_in = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        if (sel) m_b = d; else m_a = d;
        step(6);
    endtask

    initial begin
        rst_n = 1'b0; data_in = 8'h00; chan_sel = 1'b0; cs_n = 1'b1; wr_n = 1'b1;
        bipolar = 1'b0; ref_a = 16'sd1000; ref_b = -16'sd777;
        m_a = 8'h00; m_b = 8'h00;
        step(4);
        check("R1 reset out_a", out_a, 24'sd0);
        check("R1 reset out_b", out_b, 24'sd0);
        rst_n = 1'b1;
        step(2);

        // R8 latency: data write due after the fourth edge.
        @(negedge clk);
        chan_sel = 1'b0; data_in = 8'h40; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;   // edge 1 passed
        step(2);                                       // edge 3 passed
        check("R8 out_a still old after 3 edges", out_a, 24'sd0);
        step(1);                                       // edge 4 passed
        m_a = 8'h40;
        check("R8 out_a new after 4 edges", out_a, expect_out(ref_a, m_a, 1'b0));

        // R8: ref change appears after one edge.
        ref_a = 16'sd3;
        step(1);
        check("R8 ref change after 1 edge", out_a, expect_out(ref_a, m_a, 1'b0));

        // R6 corner codes.
        ref_a = 16'sd32767; ref_b = -16'sd32768;
        write(1'b0, 8'hFF); write(1'b1, 8'hFF);
        check_both("R6 full scale");
        write(1'b0, 8'h00); write(1'b1, 8'h01);
        check_both("R6 zero and one");

        // R7 corner codes.
        bipolar = 1'b1;
        write(1'b0, 8'h80); write(1'b1, 8'hFF);
        check_both("R7 mid and top");
        write(1'b0, 8'h00); write(1'b1, 8'h00);
        check_both("R7 bottom");

        // R2 / R3 plain writes.
        bipolar = 1'b0; ref_a = 16'sd1234; ref_b = 16'sd4321;
        write(1'b0, 8'hA5);
        check_both("R2 write A");
        write(1'b1, 8'h5A);
        check_both("R3 write B, R5 A unchanged");

        // R4: cs_n high, wr_n low, data moving.
        @(negedge clk); chan_sel = 1'b0; cs_n = 1'b1; wr_n = 1'b0;
        for (int i = 0; i < 4; i++) begin data_in = 8'(i * 37 + 3); @(negedge clk); end
        // R4: wr_n high, cs_n low.
        cs_n = 1'b0; wr_n = 1'b1; chan_sel = 1'b1;
        for (int i = 0; i < 4; i++) begin data_in = 8'(i * 53 + 9); @(negedge clk); end
        cs_n = 1'b1; step(6);
        check_both("R4 hold with one strobe high");

        // R9: held-open write tracks data; last value kept.
        @(negedge clk); chan_sel = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
        for (int i = 0; i < 5; i++) begin data_in = 8'(8'h10 + i); @(negedge clk); end
        wr_n = 1'b1; data_in = 8'hEE; m_b = 8'h14;
        step(6);
        check_both("R9 last value held, R5 A unchanged");

        // Random mix.
        for (int i = 0; i < 150; i++) begin
            logic s; logic [7:0] d;
            s = 1'($urandom); d = 8'($urandom);
            bipolar = 1'($urandom);
            ref_a = 16'($urandom); ref_b = 16'($urandom);
            write(s, d);
            check_both(s ? "R3 R6 R7 random B" : "R2 R6 R7 random A");
        end

        // R1: reset after activity.
        @(negedge clk); rst_n = 1'b0;
        step(2);
        check("R1 reset clears out_a", out_a, 24'sd0);
        check("R1 reset clears out_b", out_b, 24'sd0);
        rst_n = 1'b1; m_a = 8'h00; m_b = 8'h00;
        step(3);
        check_both("R1 codes zero after reset");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd20240607);
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule